// File: doc/BRIEF.md
# Shared-Multiplier Seven-Tap Adaptive Equalizer

This block is a seven-tap adaptive FIR equalizer for a slow wireless receive path running on a fast system clock (20 MHz against a symbol rate many times lower). It does not sample every clock. It takes one corrected 8-bit two's-complement sample, with its training reference, when the upstream logic requests it through a valid/ready handshake. It then filters the sample and adapts all seven coefficients. After a fixed number of clocks it presents the equalized value.

Each sample needs fourteen products: seven to form the output and seven to update the coefficients. All fourteen run on a pool of three multipliers under a fixed schedule. There are three filter cycles, where each cycle feeds three taps to the pool. Then there are three update cycles, which use the error formed from the output just computed.

The stream rules are as follows. The input side accepts a transfer only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low for the whole computation. A request that is presented while `in_ready` is low is never taken. It raises `overrun` for one cycle, so a sender that must not stall can see that its sample was lost. The output side has no back-pressure: `out_valid` is a one-cycle pulse, and the receiver must take `out_sample` in that cycle. The step-size and adapt-enable pins are plain control pins. They are captured together with each accepted sample.

Top module: `eq_shared7`

## Requirements
- R1: After reset, `in_ready`=1, `out_valid`=0 and `overrun`=0. The coefficient of tap 3 (tap 0 holds the newest sample) is +1.0, which is 1024 in a 12-bit signed value with 10 fraction bits. All other coefficients are 0. With adaptation off, the output therefore equals the input delayed by three accepted samples, and the first three outputs are 0.
- R2: A sample is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from that edge until the result edge.
- R3: `out_valid` goes high on the 6th rising edge after the accepting edge, for exactly one cycle, whatever the data. `in_ready` returns to 1 on the same edge.
- R4: The output is y = clamp(floor(sum over k of c[k]*x[k] / 1024)), where x[0] is the sample just accepted and x[k] is the sample accepted k transfers earlier.
- R5: When adaptation is enabled, each coefficient is updated after the output is formed. The error is e = ref - y, with y taken after its clamp. The update is c[k] += floor(e*x[k] / 2^(6+mu)), where mu is the 3-bit `mu_shift`.
- R6: When `adapt_en` is 0 at acceptance, no coefficient changes for that sample.
- R7: A request made while `in_ready` is 0 gives a one-cycle `overrun` pulse on the next edge. It leaves the sample history and every later output unchanged.
- R8: The output clamps to the range [-128, 127].
- R9: Each coefficient clamps to the range [-2048, 2047] after each update.
- R10: `adapt_en` and `mu_shift` are taken at the accepting edge. Changes to them during the computation have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample request |
| in_ready | output | 1 | High when idle and able to accept |
| in_sample | input | 8 | Corrected input sample, signed |
| in_ref | input | 8 | Training/decision reference for this sample, signed |
| adapt_en | input | 1 | Enables coefficient adaptation for the accepted sample |
| mu_shift | input | 3 | Step-size exponent |
| out_valid | output | 1 | One-cycle result strobe |
| out_sample | output | 8 | Equalized output, signed |
| overrun | output | 1 | Pulse flagging a request refused while busy |

## Verification
Two of the block's functions can fall in the same cycle: a refused request, and the computation already in flight that overlaps it. The bench provokes this by holding `in_valid` high, with a different sample, in the first busy cycle of a transfer. It then checks that `overrun` pulses one cycle later, and that the result of that transfer still arrives on the 6th edge. Every following output must match a model that never saw the refused sample, which shows that neither the history nor the coefficients were touched.

// File: rtl/eq_pkg.sv
package eq_pkg;
  localparam int TAPS_D      = 7;
  localparam int LANES_D     = 3;
  localparam int XW_D        = 8;
  localparam int CW_D        = 12;
  localparam int FRAC_D      = 10;
  localparam int STEP_BASE_D = 6;
  localparam int MUW_D       = 3;

  typedef enum logic [1:0] {PH_IDLE, PH_FILT, PH_UPD} phase_e;
endpackage

// File: rtl/eq_sched.sv
module eq_sched
  import eq_pkg::*;
#(
  parameter int GROUPS = 3,
  parameter int MUW    = MUW_D,
  parameter int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           adapt_en,
  input  logic [MUW-1:0] mu_shift,
  output logic           in_ready,
  output logic           accept,
  output phase_e         kind,
  output logic [GW-1:0]  grp,
  output logic           done,
  output logic           adapt_q,
  output logic [MUW-1:0] mu_q,
  output logic           overrun
);
  localparam int PHW = $clog2(2 * GROUPS + 1);
  localparam logic [PHW-1:0] LAST = PHW'(2 * GROUPS);
  localparam logic [PHW-1:0] GLIM = PHW'(GROUPS);

  logic [PHW-1:0] ph;
  logic [PHW-1:0] off;

  always_comb begin
    in_ready = (ph == '0);
    accept   = in_valid && in_ready;
    done     = (ph == LAST);
    if (ph == '0)        kind = PH_IDLE;
    else if (ph <= GLIM) kind = PH_FILT;
    else                 kind = PH_UPD;
    off = (ph <= GLIM) ? ph - PHW'(1) : ph - PHW'(1) - GLIM;
    grp = off[GW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= '0;
      adapt_q <= 1'b0;
      mu_q    <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= in_valid && (ph != '0);
      if (accept) begin
        ph      <= PHW'(1);
        adapt_q <= adapt_en;
        mu_q    <= mu_shift;
      end else if (ph == LAST) begin
        ph <= '0;
      end else if (ph != '0) begin
        ph <= ph + PHW'(1);
      end
    end
  end

  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R7
  overrun_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> !overrun || $past(in_valid));
endmodule

// File: rtl/eq_mul_pool.sv
module eq_mul_pool #(
  parameter int LANES = 3,
  parameter int AW    = 12,
  parameter int BW    = 8
) (
  input  logic [LANES-1:0][AW-1:0]    a_op,
  input  logic [LANES-1:0][BW-1:0]    b_op,
  output logic [LANES-1:0][AW+BW-1:0] prod
);
  for (genvar m = 0; m < LANES; m++) begin : g_lane
    assign prod[m] = $signed(a_op[m]) * $signed(b_op[m]);
  end
endmodule

// File: rtl/eq_coef_bank.sv
module eq_coef_bank #(
  parameter int TAPS   = 7,
  parameter int CW     = 12,
  parameter int FRAC   = 10,
  parameter int CENTER = TAPS / 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [TAPS-1:0]          wr_en,
  input  logic [TAPS-1:0][CW-1:0]  wr_data,
  output logic [TAPS-1:0][CW-1:0]  coefs
);
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    localparam logic [CW-1:0] INIT = (k == CENTER) ? CW'(1 << FRAC) : '0;
    always_ff @(posedge clk) begin
      if (!rst_n)        coefs[k] <= INIT;
      else if (wr_en[k]) coefs[k] <= wr_data[k];
    end
  end
endmodule

// File: rtl/eq_shared7.sv
module eq_shared7
  import eq_pkg::*;
#(
  parameter int TAPS      = TAPS_D,
  parameter int LANES     = LANES_D,
  parameter int XW        = XW_D,
  parameter int CW        = CW_D,
  parameter int FRAC      = FRAC_D,
  parameter int STEP_BASE = STEP_BASE_D,
  parameter int MUW       = MUW_D
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [XW-1:0]  in_sample,
  input  logic [XW-1:0]  in_ref,
  input  logic           adapt_en,
  input  logic [MUW-1:0] mu_shift,
  output logic           out_valid,
  output logic [XW-1:0]  out_sample,
  output logic           overrun
);
  localparam int GROUPS = (TAPS + LANES - 1) / LANES;
  localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int PW     = CW + XW;
  localparam int ACCW   = PW + $clog2(TAPS) + 1;
  localparam int EW     = XW + 1;
  localparam int SHW    = $clog2(STEP_BASE + (1 << MUW));
  localparam logic signed [ACCW-1:0] Y_HI = ACCW'((1 << (XW - 1)) - 1);
  localparam logic signed [ACCW-1:0] Y_LO = ~Y_HI;
  localparam logic signed [PW:0]     C_HI = (PW + 1)'((1 << (CW - 1)) - 1);
  localparam logic signed [PW:0]     C_LO = ~C_HI;

  logic            accept, done, adapt_q;
  phase_e          kind;
  logic [GW-1:0]   grp;
  logic [MUW-1:0]  mu_q;

  logic [TAPS-1:0][XW-1:0]    xline;
  logic [XW-1:0]              ref_q;
  logic signed [ACCW-1:0]     acc, acc_nx, y_wide;
  logic [XW-1:0]              y_now;
  logic signed [EW-1:0]       err;
  logic [LANES-1:0][CW-1:0]   a_op;
  logic [LANES-1:0][XW-1:0]   b_op;
  logic [LANES-1:0][PW-1:0]   prod;
  logic [TAPS-1:0][CW-1:0]    coefs, wr_data;
  logic [TAPS-1:0]            wr_en;
  logic [SHW-1:0]             shamt;
  int                         lane_idx [LANES];
  logic [LANES-1:0]           lane_live;

  eq_sched #(.GROUPS(GROUPS), .MUW(MUW)) u_sched (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .adapt_en(adapt_en),
    .mu_shift(mu_shift), .in_ready(in_ready), .accept(accept), .kind(kind),
    .grp(grp), .done(done), .adapt_q(adapt_q), .mu_q(mu_q), .overrun(overrun)
  );

  eq_mul_pool #(.LANES(LANES), .AW(CW), .BW(XW)) u_pool (
    .a_op(a_op), .b_op(b_op), .prod(prod)
  );

  eq_coef_bank #(.TAPS(TAPS), .CW(CW), .FRAC(FRAC)) u_coef (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .coefs(coefs)
  );

  // Output clamp and error from the accumulated filter sum
  always_comb begin
    y_wide = acc >>> FRAC;
    if (y_wide > Y_HI)      y_now = XW'(Y_HI);
    else if (y_wide < Y_LO) y_now = XW'(Y_LO);
    else                    y_now = y_wide[XW-1:0];
    err   = EW'($signed(ref_q)) - EW'($signed(y_now));
    shamt = SHW'(STEP_BASE) + SHW'(mu_q);
  end

  // Operand steering into the shared multipliers
  always_comb begin
    for (int m = 0; m < LANES; m++) begin
      lane_idx[m]  = int'(grp) * LANES + m;
      lane_live[m] = (kind != PH_IDLE) && (lane_idx[m] < TAPS);
      a_op[m] = '0;
      b_op[m] = '0;
      if (lane_live[m]) begin
        b_op[m] = xline[lane_idx[m]];
        a_op[m] = (kind == PH_UPD) ? {{(CW - EW){err[EW-1]}}, err}
                                   : coefs[lane_idx[m]];
      end
    end
  end

  // Filter accumulation and coefficient write-back
  always_comb begin
    logic signed [PW-1:0] delta;
    logic signed [PW:0]   cand;
    acc_nx  = acc;
    wr_en   = '0;
    wr_data = coefs;
    for (int m = 0; m < LANES; m++) begin
      delta = $signed(prod[m]) >>> shamt;
      cand  = (PW + 1)'($signed(coefs[lane_live[m] ? lane_idx[m] : 0]))
            + (PW + 1)'(delta);
      if (lane_live[m] && kind == PH_FILT)
        acc_nx = acc_nx + ACCW'($signed(prod[m]));
      if (lane_live[m] && kind == PH_UPD && adapt_q) begin
        wr_en[lane_idx[m]] = 1'b1;
        if (cand > C_HI)      wr_data[lane_idx[m]] = CW'(C_HI);
        else if (cand < C_LO) wr_data[lane_idx[m]] = CW'(C_LO);
        else                  wr_data[lane_idx[m]] = cand[CW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xline      <= '0;
      ref_q      <= '0;
      acc        <= '0;
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= done;
      if (done) out_sample <= y_now;
      if (accept) begin
        xline <= {xline[TAPS-2:0], in_sample};
        ref_q <= in_ref;
        acc   <= '0;
      end else begin
        acc <= acc_nx;
      end
    end
  end

  // Cycle counter used only by the latency check
  logic [3:0] lat_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)              lat_cnt <= 4'hF;
    else if (accept)         lat_cnt <= 4'd1;
    else if (lat_cnt != 4'hF) lat_cnt <= lat_cnt + 4'd1;
  end

  // R3
  result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> lat_cnt == 4'(2 * GROUPS + 1));

  // R3
  result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R6
  coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != PH_UPD || !adapt_q) |=> $stable(coefs));

  // R7
  overrun_no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $stable(xline));
endmodule

// File: tb/sim_eq_shared7.sv
module sim_eq_shared7;
  localparam int CLK_PERIOD = 50;
  localparam int WATCHDOG   = 150000;

  localparam int NTAB = 10;
  localparam int TAB_X [NTAB] = '{5, -7, 100, -128, 127, 1, -1, 0, 64, -90};
  localparam int TAB_Y [NTAB] = '{0, 0, 0, 5, -7, 100, -128, 127, 1, -1};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_sample = '0;
  logic [7:0] in_ref = '0;
  logic       adapt_en = 1'b0;
  logic [2:0] mu_shift = '0;
  logic       in_ready, out_valid, overrun;
  logic [7:0] out_sample;

  int n_run = 0;
  int n_fail = 0;
  int mx [7];
  int mc [7];

  always #(CLK_PERIOD / 2) clk = ~clk;

  eq_shared7 u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .in_ref(in_ref), .adapt_en(adapt_en),
    .mu_shift(mu_shift), .out_valid(out_valid), .out_sample(out_sample),
    .overrun(overrun)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int clampi(input int v, input int lo, input int hi);
    return (v > hi) ? hi : (v < lo) ? lo : v;
  endfunction

  function automatic int model_step(input int s, input int r, input bit a, input int mu);
    int acc, y, e;
    for (int k = 6; k > 0; k--) mx[k] = mx[k-1];
    mx[0] = s;
    acc = 0;
    for (int k = 0; k < 7; k++) acc += mc[k] * mx[k];
    y = clampi(acc >>> 10, -128, 127);
    e = r - y;
    if (a)
      for (int k = 0; k < 7; k++)
        mc[k] = clampi(mc[k] + ((e * mx[k]) >>> (6 + mu)), -2048, 2047);
    return y;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 7; k++) begin
      mx[k] = 0;
      mc[k] = (k == 3) ? 1024 : 0;
    end
    @(negedge clk);
    check(in_ready === 1'b1, "R1 ready after reset", int'(in_ready), 1);
    check(out_valid === 1'b0, "R1 valid after reset", int'(out_valid), 0);
    check(overrun === 1'b0, "R1 overrun after reset", int'(overrun), 0);
  endtask

  // One transfer; returns design output and model output
  task automatic xfer(input int s, input int r, input bit a, input int mu,
                      input bit inject, output int got, output int exp);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_sample = 8'(s);
    in_ref = 8'(r);
    adapt_en = a;
    mu_shift = 3'(mu);
    @(negedge clk);
    exp = model_step(s, r, a, mu);
    // R10: disturb the control pins while busy
    adapt_en = !a;
    mu_shift = 3'(~mu);
    check(in_ready === 1'b0, "R2 ready low while busy", int'(in_ready), 0);
    if (inject) begin
      in_sample = 8'd99;
      in_ref = 8'd120;
      @(negedge clk);
      check(overrun === 1'b1, "R7 overrun raised", int'(overrun), 1);
      in_valid = 1'b0;
      @(negedge clk);
      check(overrun === 1'b0, "R7 overrun one cycle", int'(overrun), 0);
      repeat (3) @(negedge clk);
    end else begin
      in_valid = 1'b0;
      repeat (5) @(negedge clk);
    end
    check(out_valid === 1'b0, "R3 no early valid", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid === 1'b1, "R3 valid on 6th edge", int'(out_valid), 1);
    check(in_ready === 1'b1, "R3 ready back with result", int'(in_ready), 1);
    got = int'($signed(out_sample));
    @(negedge clk);
    check(out_valid === 1'b0, "R3 valid single cycle", int'(out_valid), 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int got, exp, lfsr;
    do_reset();

    // R1 R4 R6: table walk with adaptation off, output is input delayed by three
    for (int i = 0; i < NTAB; i++) begin
      xfer(TAB_X[i], 0, 1'b0, 0, 1'b0, got, exp);
      check(got == TAB_Y[i], "R1 R4 delayed identity", got, TAB_Y[i]);
      check(got == exp, "R6 frozen coefficients", got, exp);
    end

    // R5 R10: adaptation with varied step sizes and patterns
    lfsr = 32'h1F3A;
    for (int i = 0; i < 40; i++) begin
      lfsr = (lfsr << 1) ^ (((lfsr >> 15) ^ (lfsr >> 13)) & 1);
      xfer(((lfsr & 255) - 128), (((lfsr >> 8) & 255) - 128), 1'b1, i % 8,
           1'b0, got, exp);
      check(got == exp, "R5 R10 adaptive output", got, exp);
    end

    // R7: refused request during computation leaves history untouched
    xfer(33, -20, 1'b1, 2, 1'b1, got, exp);
    check(got == exp, "R7 result of accepted sample", got, exp);
    for (int i = 0; i < 8; i++) begin
      xfer(10 * i - 40, 15, 1'b0, 0, 1'b0, got, exp);
      check(got == exp, "R7 later outputs unaffected", got, exp);
    end

    // R9: drive all coefficients to the positive limit
    do_reset();
    for (int i = 0; i < 1500; i++) begin
      xfer(8, 127, 1'b1, 0, 1'b0, got, exp);
      if (got != exp) check(1'b0, "R9 saturation run", got, exp);
    end
    xfer(8, 127, 1'b0, 0, 1'b0, got, exp);
    check(got == 111, "R9 coefficients clamped at 2047", got, 111);

    // R8: output clamp in both directions with maximal coefficients
    for (int i = 0; i < 7; i++) xfer(127, 0, 1'b0, 0, 1'b0, got, exp);
    check(got == 127, "R8 positive clamp", got, 127);
    for (int i = 0; i < 7; i++) xfer(-128, 0, 1'b0, 0, 1'b0, got, exp);
    check(got == -128, "R8 negative clamp", got, -128);

    // R1: reset mid-stream restores initial coefficients
    do_reset();
    for (int i = 0; i < 4; i++) xfer(20 + i, 0, 1'b0, 0, 1'b0, got, exp);
    check(got == 20, "R1 centre tap restored", got, 20);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule